// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block is the clocked controller that sits beside an SRAM backed by a nonvolatile shadow array. Two supply comparator flags drive it. One says the supply is above the upper switch threshold. The other says the supply is above the lower reset threshold. It also watches the host SRAM strobes, chip enable and write enable. It keeps a dirty flag that records whether the SRAM holds data the shadow array does not yet have.

When the supply falls below the switch threshold, the controller waits a short grace window so that a host cycle already in flight can finish. It then copies the SRAM into the shadow array, but only if something was written since the last transfer. On power-up it copies the shadow back into the SRAM, but only if the supply really sank below the reset threshold since the last copy-back. A shallow brown-out therefore resumes normal operation with the SRAM contents left as they are. While a transfer runs, host access is inhibited, and the standby permission is held off.

The grace, store and recall windows are cycle-count parameters. The defaults are scaled so that the block elaborates quickly, and an integration sets them from its clock rate (about 1 µs, 10 ms and 550 µs). A 3-bit status output exposes the sequencer phase.

Top module: `nvsram_pfail_ctrl`

## Requirements
- R1: After reset the status is OFF (code 4), host_block is 1, and both transfer strobes are 0. The power-on state counts as a deep dip, so the first power-up performs a recall.
- R2: In OFF with supply_hi = 1 and a deep dip recorded, the status becomes RECALL (code 3). recall_go is then high for exactly RECALL_CYC cycles, with host_block high, and the status ends in IDLE (code 0).
- R3: A host write is counted in a cycle where host_ce = 1, host_we = 1 and host_block = 0. A counted write marks the SRAM dirty.
- R4: In IDLE, supply_hi = 0 moves the status to DELAY (code 1) for DELAY_CYC cycles. host_block stays 0 during DELAY, and writes made during DELAY are counted.
- R5: At the end of DELAY with the SRAM dirty, store_go is high for exactly STORE_CYC cycles, with host_block high and status STORE (code 2). The status then becomes OFF.
- R6: At the end of DELAY with the SRAM clean, no store takes place and the status goes straight to OFF.
- R7: The dirty mark is cleared when a store completes and when a recall completes.
- R8: A deep dip is recorded whenever supply_ok = 0. It is cleared only by a completed recall. In OFF with supply_hi = 1 and no deep dip recorded, the status returns to IDLE with no recall.
- R9: A store that has started runs its full length even if supply_hi returns to 1 meanwhile. The recall decision is made only afterwards, from OFF.
- R10: standby_ok is 1 only when host_ce = 0 and neither store_go nor recall_go is high.
- R11: Status codes are IDLE = 0, DELAY = 1, STORE = 2, RECALL = 3, OFF = 4. store_go and recall_go are never high together.
- R12: supply_hi = 0 during RECALL aborts the recall to OFF, with the deep dip still recorded. The next power-up performs a full recall.
- R13: Writes presented while host_block = 1 are ignored. A power-down after a recall, with only such writes in between, performs no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_hi | input | 1 | Supply is above the switch threshold |
| supply_ok | input | 1 | Supply is above the reset threshold |
| host_ce | input | 1 | Host chip enable, active high |
| host_we | input | 1 | Host write enable, active high |
| store_go | output | 1 | Array SRAM-to-shadow transfer strobe |
| recall_go | output | 1 | Array shadow-to-SRAM transfer strobe |
| host_block | output | 1 | Host SRAM access inhibited |
| standby_ok | output | 1 | Low-power standby may be entered |
| status | output | 3 | Sequencer phase code |

## Verification
The assertions take the comparator flags as ordered: supply_ok may fall only while supply_hi is already low, and supply_hi may rise only while supply_ok is high. They also take the cycle-count parameters as at least one. The stimulus respects this ordering. It lowers supply_hi before pulsing supply_ok low, and raises supply_ok before or together with supply_hi. Host strobes change only at falling clock edges, so a write spans whole cycles. The sweep walks every mix of a prior write, a deep or shallow dip, and an early or late supply return, and predicts the strobe lengths from the parameters.

// File: rtl/nvpc_pkg.sv
package nvpc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DELAY  = 3'd1,
    PH_STORE  = 3'd2,
    PH_RECALL = 3'd3,
    PH_OFF    = 3'd4
  } nv_phase_e;

  // A phase lasting n cycles loads n-1 into the down counter; zero is treated as one.
  function automatic int unsigned phase_load(int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvpc_timer.sv
module nvpc_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R5: each phase window shrinks by one per cycle until it runs out
  assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_timer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);
endmodule

// File: rtl/nvpc_dirty.sv
module nvpc_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic host_ce,
  input  logic host_we,
  input  logic blocked,
  input  logic clr,
  output logic wr_evt,
  output logic dirty_q
);
  assign wr_evt = host_ce && host_we && !blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dirty_q <= 1'b0;
    else if (wr_evt) dirty_q <= 1'b1;
    else if (clr)    dirty_q <= 1'b0;
  end

  assert_write_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> dirty_q);
  assert_clear_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_evt) |=> !dirty_q);
  assert_blocked_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !clr && !dirty_q) |=> !dirty_q);
endmodule

// File: rtl/nvpc_dip.sv
module nvpc_dip (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic clr,
  output logic low_seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_seen <= 1'b1;
    else if (!supply_ok) low_seen <= 1'b1;
    else if (clr)        low_seen <= 1'b0;
  end

  assert_dip_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> low_seen);
  assert_dip_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (low_seen && !clr) |=> low_seen);
endmodule

// File: rtl/nvsram_pfail_ctrl.sv
module nvsram_pfail_ctrl #(
  parameter int unsigned DELAY_CYC  = 100,
  parameter int unsigned STORE_CYC  = 1000,
  parameter int unsigned RECALL_CYC = 550
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_hi,
  input  logic       supply_ok,
  input  logic       host_ce,
  input  logic       host_we,
  output logic       store_go,
  output logic       recall_go,
  output logic       host_block,
  output logic       standby_ok,
  output logic [2:0] status
);
  import nvpc_pkg::*;

  localparam int unsigned LONGEST = max3(DELAY_CYC, STORE_CYC, RECALL_CYC);
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1) + 1;
  localparam logic [CNT_W-1:0] LD_DELAY  = CNT_W'(phase_load(DELAY_CYC));
  localparam logic [CNT_W-1:0] LD_STORE  = CNT_W'(phase_load(STORE_CYC));
  localparam logic [CNT_W-1:0] LD_RECALL = CNT_W'(phase_load(RECALL_CYC));

  nv_phase_e        ph_q, ph_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             wr_evt, dirty_q, low_seen;
  logic             store_done, recall_done;

  nvpc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  nvpc_dirty u_dirty (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_we(host_we),
    .blocked(host_block), .clr(store_done || recall_done),
    .wr_evt(wr_evt), .dirty_q(dirty_q)
  );

  nvpc_dip u_dip (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .clr(recall_done), .low_seen(low_seen)
  );

  always_comb begin
    ph_d        = ph_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    store_done  = 1'b0;
    recall_done = 1'b0;
    case (ph_q)
      PH_OFF: if (supply_hi) begin
        if (low_seen) begin
          ph_d = PH_RECALL; tmr_load = 1'b1; tmr_val = LD_RECALL;
        end else begin
          ph_d = PH_IDLE;
        end
      end
      PH_IDLE: if (!supply_hi) begin
        ph_d = PH_DELAY; tmr_load = 1'b1; tmr_val = LD_DELAY;
      end
      PH_DELAY: if (tmr_expired) begin
        if (dirty_q || wr_evt) begin
          ph_d = PH_STORE; tmr_load = 1'b1; tmr_val = LD_STORE;
        end else begin
          ph_d = PH_OFF;
        end
      end
      PH_STORE: if (tmr_expired) begin
        ph_d = PH_OFF; store_done = 1'b1;
      end
      PH_RECALL: begin
        if (!supply_hi)       ph_d = PH_OFF;
        else if (tmr_expired) begin
          ph_d = PH_IDLE; recall_done = 1'b1;
        end
      end
      default: ph_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_OFF;
    else        ph_q <= ph_d;
  end

  assign store_go   = (ph_q == PH_STORE);
  assign recall_go  = (ph_q == PH_RECALL);
  assign host_block = store_go || recall_go || (ph_q == PH_OFF);
  assign standby_ok = !host_ce && !store_go && !recall_go;
  assign status     = ph_q;

  assert_store_needs_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_go) |-> $past(dirty_q || wr_evt));
  assert_recall_needs_dip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_go) |-> $past(low_seen && supply_hi));
  assert_store_runs_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_go && !tmr_expired) |=> store_go);
  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_go, recall_go}));
  assert_no_standby_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_go || recall_go) |-> !standby_ok);
  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_go || recall_go) |-> host_block);
  assert_abort_to_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_go && !supply_hi) |=> (status == 3'd4 && low_seen));
endmodule

// File: tb/nvsram_pfail_ctrl_test.sv
module nvsram_pfail_ctrl_test;
  localparam int D = 3;
  localparam int S = 8;
  localparam int R = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_hi = 1'b0, supply_ok = 1'b0, host_ce = 1'b0, host_we = 1'b0;
  logic store_go, recall_go, host_block, standby_ok;
  logic [2:0] status;

  int n_chk = 0, n_fail = 0;
  int st_cnt = 0, rc_cnt = 0, cyc = 0;
  bit done = 0;

  nvsram_pfail_ctrl #(.DELAY_CYC(D), .STORE_CYC(S), .RECALL_CYC(R)) uut (
    .clk(clk), .rst_n(rst_n), .supply_hi(supply_hi), .supply_ok(supply_ok),
    .host_ce(host_ce), .host_we(host_we), .store_go(store_go), .recall_go(recall_go),
    .host_block(host_block), .standby_ok(standby_ok), .status(status)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (store_go)  st_cnt <= st_cnt + 1;
    if (recall_go) rc_cnt <= rc_cnt + 1;
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) if (!done && cyc > 20000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, actual %0d cycles expected < 20000", cyc);
    report();
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write();
    host_ce = 1; host_we = 1; tick(1);
    host_ce = 0; host_we = 0; tick(1);
  endtask

  // one power-down / power-up cycle; expected strobe lengths follow R5, R6, R2, R8, R9
  task automatic cycle_case(bit wr, bit deep, bit early);
    int s0, r0;
    if (wr) host_write();
    s0 = st_cnt; r0 = rc_cnt;
    supply_hi = 0; tick(1);
    check("R4 delay status", status, 1);
    check("R4 no block in delay", host_block, 0);
    if (deep) supply_ok = 0;
    tick(2);
    supply_ok = 1;
    tick(D);
    if (wr) begin
      check("R5 store status", status, 2);
      check("R10 no standby while storing", standby_ok, 0);
    end else begin
      check("R6 clean goes off", status, 4);
    end
    if (!early) tick(S + 4);
    supply_hi = 1;
    tick(S + R + 6);
    check($sformatf("R5/R9 store length w%0d d%0d e%0d", wr, deep, early), st_cnt - s0, wr ? S : 0);
    check($sformatf("R8 recall length w%0d d%0d e%0d", wr, deep, early), rc_cnt - r0, deep ? R : 0);
    check("R11 back to idle", status, 0);
  endtask

  initial begin
    int s0, r0;
    tick(3);
    rst_n = 1; tick(1);
    check("R1 reset status", status, 4);
    check("R1 reset block", host_block, 1);
    check("R1 reset strobes", {store_go, recall_go}, 0);
    check("R10 standby in off", standby_ok, 1);

    r0 = rc_cnt;
    supply_ok = 1; supply_hi = 1; tick(1);
    check("R2 recall status", status, 3);
    tick(R + 3);
    check("R2 recall length", rc_cnt - r0, R);
    check("R2 idle after recall", status, 0);
    check("R2 unblocked", host_block, 0);

    host_ce = 1; tick(1);
    check("R10 selected no standby", standby_ok, 0);
    host_ce = 0; tick(1);
    check("R10 deselected standby", standby_ok, 1);

    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 2; d++)
        for (int e = 0; e < 2; e++)
          cycle_case(w[0], d[0], e[0]);

    // R7: the sweep ends after a store and a recall; a clean power-down must not store
    cycle_case(1'b0, 1'b0, 1'b0);

    // R4: a write inside the grace window is counted
    s0 = st_cnt;
    supply_hi = 0; tick(1);
    host_write();
    tick(S + 6);
    check("R4 write in delay stored", st_cnt - s0, S);
    supply_hi = 1; tick(4);
    check("R8 shallow dip no recall", status, 0);

    // R13: writes while blocked by recall are ignored
    supply_hi = 0; supply_ok = 0; tick(D + 4);
    supply_ok = 1; supply_hi = 1; tick(2);
    check("R13 in recall", status, 3);
    host_write();
    tick(R + 2);
    check("R13 idle", status, 0);
    s0 = st_cnt;
    supply_hi = 0; tick(D + 4);
    check("R13 blocked write no store", st_cnt - s0, 0);
    check("R13 off", status, 4);
    supply_hi = 1; tick(3);
    check("R7 dip cleared by recall", status, 0);

    // R12: recall aborted by a second drop, then repeated in full
    supply_hi = 0; supply_ok = 0; tick(D + 4);
    supply_ok = 1; supply_hi = 1; tick(3);
    check("R12 recall running", status, 3);
    supply_hi = 0; tick(2);
    check("R12 aborted to off", status, 4);
    check("R12 strobe dropped", recall_go, 0);
    r0 = rc_cnt;
    supply_hi = 1; tick(R + 4);
    check("R12 full recall after abort", rc_cnt - r0, R);
    check("R12 idle", status, 0);

    done = 1;
    report();
  end
endmodule